// File: doc/BRIEF.md
# Per-Lane Event Counter Unit

This block counts how often one chosen link event fires on one chosen lane. The link logic around it delivers a flat bus of single-cycle event pulses. The pulses are grouped by event group, then by event number inside the group, then by lane. A host programs a 32-bit control word through a simple register write port, which selects the group, the event and the lane. The same write can also issue an enable or clear command. The host reads back the control word and a 32-bit count word on the same port.

The enable and clear fields carry multi-bit command codes, not plain level bits. A code acts once, in the cycle of the write, and any code that is not defined leaves the block unchanged. Enabling does not reset the count. Only an explicit clear command returns it to zero. When one write carries both a clear and an enable, counting starts from zero.

Top module: `lane_event_counter`

## Requirements
- R1: After synchronous reset, counting is off and both the control word (offset 0x8) and the count word (offset 0xC) read as zero.
- R2: A write to offset 0x8 stores the group number from bits 27:24, the event number from bits 23:16 and the lane from bits 11:8. Reading offset 0x8 returns these fields in the same positions, shows the counting state in bit 7, and reads zero in every other bit, including bits 4:0.
- R3: In a control write, the enable code in bits 4:2 turns counting on when it is 3'b011 and off when it is 3'b001. Every other code leaves the counting state unchanged. The new state applies from the next cycle.
- R4: In a control write, the clear code 2'b01 in bits 1:0 sets the count to zero. Every other clear code leaves the count unchanged.
- R5: When one control write carries both the clear code and the enable-on code, the count becomes zero, the pulse in that write cycle is not counted, and counting continues upward from zero.
- R6: While counting is on, the count rises by exactly one in each cycle where the selected pulse is high. The selected pulse is bus bit ((group*EVENTS_PER_GROUP)+event)*NUM_LANES+lane. The selection held before a write applies during the write cycle.
- R7: While counting is off, the count holds. Turning counting on does not change the count.
- R8: A selection with lane >= NUM_LANES, group >= NUM_GROUPS or event >= EVENTS_PER_GROUP never increments the count, whatever the pulse bus carries.
- R9: The count wraps to zero modulo 2^CNT_W (32 bits by default) and reads zero-extended to 32 bits.
- R10: Writes to any offset other than 0x8, offset 0xC included, change neither the control state nor the count. Reads of any offset other than 0x8 and 0xC return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Byte offset for the register read and write |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| evt_pulse | input | NUM_GROUPS*EVENTS_PER_GROUP*NUM_LANES | Single-cycle event pulses, one bit per group, event and lane |

## Verification
The bench builds the block with NUM_LANES=4, NUM_GROUPS=8, EVENTS_PER_GROUP=6 and CNT_W=10. The narrow count makes the wrap reachable in 1024 selected pulses, and the small lane and event counts make out-of-range selections frequent under random control writes. The pulse bus is 192 bits wide, so dense random pulses reach the selected bit often while every other bit is tested for leakage into the count. Directed steps cover a clear and an enable in the same write, undefined command codes, and a selection change that occurs in a cycle where a pulse is present.

// File: rtl/lec_pkg.sv
package lec_pkg;

    localparam int REG_W     = 32;
    localparam int OFS_CTRL  = 8'h08;
    localparam int OFS_COUNT = 8'h0C;

    localparam logic [2:0] EN_CMD_ON  = 3'b011;
    localparam logic [2:0] EN_CMD_OFF = 3'b001;
    localparam logic [1:0] CLR_CMD_DO = 2'b01;

    typedef struct packed {
        logic [3:0] grp;
        logic [7:0] evt;
        logic [3:0] lane;
    } evsel_t;

    typedef struct packed {
        logic   wr;
        evsel_t sel;
        logic   en_on;
        logic   en_off;
        logic   clr;
    } ctrl_cmd_t;

    function automatic ctrl_cmd_t decode_ctrl(input logic wr, input logic [REG_W-1:0] d);
        ctrl_cmd_t c;
        c.wr       = wr;
        c.sel.grp  = d[27:24];
        c.sel.evt  = d[23:16];
        c.sel.lane = d[11:8];
        c.en_on    = wr && (d[4:2] == EN_CMD_ON);
        c.en_off   = wr && (d[4:2] == EN_CMD_OFF);
        c.clr      = wr && (d[1:0] == CLR_CMD_DO);
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_ctrl(input evsel_t s, input logic en);
        return {4'b0, s.grp, s.evt, 4'b0, s.lane, en, 7'b0};
    endfunction

endpackage

// File: rtl/lec_ctrl_regs.sv
module lec_ctrl_regs
    import lec_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic [REG_W-1:0]    reg_wdata,
    output evsel_t              sel_o,
    output logic                en_o,
    output logic                clr_o,
    output logic [REG_W-1:0]    ctrl_rd_o
);

    logic      wr_ctrl;
    ctrl_cmd_t cmd;
    evsel_t    sel_q;
    logic      en_q;
    logic      unused_wbits;

    assign wr_ctrl      = reg_wr && (reg_addr == ADDR_W'(OFS_CTRL));
    assign cmd          = decode_ctrl(wr_ctrl, reg_wdata);
    assign unused_wbits = ^{reg_wdata[31:28], reg_wdata[15:12], reg_wdata[7:5]};

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            en_q  <= 1'b0;
        end else if (cmd.wr) begin
            sel_q <= cmd.sel;
            if (cmd.en_on)
                en_q <= 1'b1;
            else if (cmd.en_off)
                en_q <= 1'b0;
        end
    end

    assign sel_o     = sel_q;
    assign en_o      = en_q;
    assign clr_o     = cmd.clr;
    assign ctrl_rd_o = pack_ctrl(sel_q, en_q);

    // R3: the on code enables counting from the next cycle
    a_r3_enable_on: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ADDR_W'(OFS_CTRL) && reg_wdata[4:2] == 3'b011) |=> en_o);

    // R3: the off code disables counting from the next cycle
    a_r3_enable_off: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ADDR_W'(OFS_CTRL) && reg_wdata[4:2] == 3'b001) |=> !en_o);

    // R3: undefined enable codes keep the state
    a_r3_enable_keep: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ADDR_W'(OFS_CTRL) && reg_wdata[4:2] != 3'b011
         && reg_wdata[4:2] != 3'b001) |=> $stable(en_o));

    // R10: writes elsewhere leave the control state alone
    a_r10_other_offset: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr != ADDR_W'(OFS_CTRL)) |=> ($stable(sel_o) && $stable(en_o)));

endmodule

// File: rtl/lec_event_mux.sv
module lec_event_mux
    import lec_pkg::*;
#(
    parameter int NUM_GROUPS       = 8,
    parameter int EVENTS_PER_GROUP = 20,
    parameter int NUM_LANES        = 4,
    localparam int BUS_W           = NUM_GROUPS * EVENTS_PER_GROUP * NUM_LANES,
    localparam int IDX_W           = (BUS_W > 1) ? $clog2(BUS_W) : 1
) (
    input  evsel_t             sel_i,
    input  logic [BUS_W-1:0]   pulse_i,
    output logic               sel_valid_o,
    output logic               hit_o
);

    logic [31:0]      idx_full;
    logic [IDX_W-1:0] idx;

    always_comb begin
        sel_valid_o = (int'(sel_i.grp)  < NUM_GROUPS) &&
                      (int'(sel_i.evt)  < EVENTS_PER_GROUP) &&
                      (int'(sel_i.lane) < NUM_LANES);
        idx_full = 32'((int'(sel_i.grp) * EVENTS_PER_GROUP + int'(sel_i.evt)) * NUM_LANES
                       + int'(sel_i.lane));
        idx      = idx_full[IDX_W-1:0];
        hit_o    = sel_valid_o ? pulse_i[idx] : 1'b0;
    end

    logic unused_idx;
    assign unused_idx = ^idx_full;

endmodule

// File: rtl/lec_counter.sv
module lec_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic             hit_i,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i)
            cnt_q <= '0;
        else if (en_i && hit_i)
            cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    // R4: a clear command empties the count
    a_r4_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (cnt_o == '0));

    // R7: no enable or no pulse holds the count
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !(en_i && hit_i)) |=> $stable(cnt_o));

    // R6/R9: a counted pulse adds exactly one, wrapping at the width
    a_r6_step_one: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && en_i && hit_i) |=> (cnt_o == CNT_W'($past(cnt_o) + 1'b1)));

endmodule

// File: rtl/lane_event_counter.sv
module lane_event_counter
    import lec_pkg::*;
#(
    parameter int NUM_LANES        = 4,
    parameter int NUM_GROUPS       = 8,
    parameter int EVENTS_PER_GROUP = 20,
    parameter int CNT_W            = 32,
    parameter int ADDR_W           = 8
) (
    input  logic                                              clk,
    input  logic                                              rst,
    input  logic [ADDR_W-1:0]                                 reg_addr,
    input  logic                                              reg_wr,
    input  logic [31:0]                                       reg_wdata,
    output logic [31:0]                                       reg_rdata,
    input  logic [NUM_GROUPS*EVENTS_PER_GROUP*NUM_LANES-1:0]  evt_pulse
);

    evsel_t            sel;
    logic              en;
    logic              clr;
    logic              sel_valid;
    logic              hit;
    logic [REG_W-1:0]  ctrl_rd;
    logic [CNT_W-1:0]  cnt;

    lec_ctrl_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .sel_o     (sel),
        .en_o      (en),
        .clr_o     (clr),
        .ctrl_rd_o (ctrl_rd)
    );

    lec_event_mux #(
        .NUM_GROUPS       (NUM_GROUPS),
        .EVENTS_PER_GROUP (EVENTS_PER_GROUP),
        .NUM_LANES        (NUM_LANES)
    ) u_mux (
        .sel_i       (sel),
        .pulse_i     (evt_pulse),
        .sel_valid_o (sel_valid),
        .hit_o       (hit)
    );

    lec_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr_i (clr),
        .en_i  (en),
        .hit_i (hit),
        .cnt_o (cnt)
    );

    always_comb begin
        if (reg_addr == ADDR_W'(OFS_CTRL))
            reg_rdata = ctrl_rd;
        else if (reg_addr == ADDR_W'(OFS_COUNT))
            reg_rdata = 32'(cnt);
        else
            reg_rdata = '0;
    end

    // R8: an out-of-range lane never produces a hit
    a_r8_lane_range: assert property (@(posedge clk) disable iff (rst)
        (int'(sel.lane) >= NUM_LANES) |-> !hit);

    // R8: an invalid selection never moves the count
    a_r8_no_count: assert property (@(posedge clk) disable iff (rst)
        (!sel_valid && !clr) |=> $stable(cnt));

    // R1: after reset the counter is idle and empty
    a_r1_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (!en && cnt == '0));

endmodule

// File: tb/lane_event_counter_test.sv
`timescale 1ns/1ps
module lane_event_counter_test;

    localparam int NL  = 4;
    localparam int NG  = 8;
    localparam int EPG = 6;
    localparam int CW  = 10;
    localparam int AW  = 8;
    localparam int BUS = NG * EPG * NL;

    logic            clk = 1'b0;
    logic            rst;
    logic [AW-1:0]   reg_addr;
    logic            reg_wr;
    logic [31:0]     reg_wdata;
    logic [31:0]     reg_rdata;
    logic [BUS-1:0]  pulses;

    int          m_grp, m_evt, m_lane;
    bit          m_en;
    int unsigned m_cnt;
    int          total = 0;
    int          fails = 0;

    always #2 clk = ~clk;

    lane_event_counter #(
        .NUM_LANES(NL), .NUM_GROUPS(NG), .EVENTS_PER_GROUP(EPG), .CNT_W(CW), .ADDR_W(AW)
    ) uut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(pulses)
    );

    function automatic bit sel_ok();
        return (m_grp < NG) && (m_evt < EPG) && (m_lane < NL);
    endfunction

    function automatic int sel_index();
        return ((m_grp * EPG) + m_evt) * NL + m_lane;
    endfunction

    function automatic bit model_hit(logic [BUS-1:0] p);
        if (!sel_ok()) return 1'b0;
        return p[sel_index()];
    endfunction

    function automatic logic [31:0] exp_ctrl();
        return {4'b0, 4'(m_grp), 8'(m_evt), 4'b0, 4'(m_lane), m_en, 7'b0};
    endfunction

    function automatic logic [31:0] ctrl_word(int g, int e, int l, logic [2:0] ec, logic [1:0] cc);
        return {4'b0, 4'(g), 8'(e), 4'b0, 4'(l), 3'b0, ec, cc};
    endfunction

    function automatic logic [BUS-1:0] rand_pulses();
        logic [BUS-1:0] r;
        for (int i = 0; i < BUS; i++) r[i] = 1'($urandom % 2);
        return r;
    endfunction

    function automatic logic [BUS-1:0] only_selected();
        logic [BUS-1:0] r = '0;
        if (sel_ok()) r[sel_index()] = 1'b1;
        return r;
    endfunction

    task automatic model_edge();
        bit do_clr;
        if (rst) begin
            m_grp = 0; m_evt = 0; m_lane = 0; m_en = 0; m_cnt = 0;
        end else begin
            do_clr = reg_wr && reg_addr == AW'(8'h08) && reg_wdata[1:0] == 2'b01;
            if (do_clr)
                m_cnt = 0;
            else if (m_en && model_hit(pulses))
                m_cnt = (m_cnt + 1) % (1 << CW);
            if (reg_wr && reg_addr == AW'(8'h08)) begin
                m_grp  = int'(reg_wdata[27:24]);
                m_evt  = int'(reg_wdata[23:16]);
                m_lane = int'(reg_wdata[11:8]);
                if (reg_wdata[4:2] == 3'b011) m_en = 1;
                else if (reg_wdata[4:2] == 3'b001) m_en = 0;
            end
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        #1;
    endtask

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic read_chk(logic [AW-1:0] a, logic [31:0] exp, string req, string what);
        reg_addr = a;
        #1;
        check(req, what, reg_rdata, exp);
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d, logic [BUS-1:0] p);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        pulses    = p;
        tick();
        reg_wr    = 1'b0;
        pulses    = '0;
    endtask

    task automatic run(int n, int mode);
        for (int i = 0; i < n; i++) begin
            case (mode)
                0: pulses = only_selected();
                1: pulses = ~only_selected();
                2: pulses = '1;
                default: pulses = rand_pulses();
            endcase
            tick();
        end
        pulses = '0;
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", total, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; pulses = '0;
        repeat (3) tick();
        rst = 1'b0;
        tick();

        read_chk(8'h08, 32'h0, "R1", "ctrl after reset");
        read_chk(8'h0C, 32'h0, "R1", "count after reset");

        wr(8'h08, ctrl_word(1, 2, 3, 3'b011, 2'b01), '0);
        read_chk(8'h08, exp_ctrl(), "R2", "ctrl readback, status on, low bits zero");
        check("R3", "status bit after on code", {31'b0, reg_rdata[7]}, 32'd1);

        run(5, 0);
        read_chk(8'h0C, 32'(m_cnt), "R6", "five selected pulses");
        run(4, 1);
        read_chk(8'h0C, 32'(m_cnt), "R6", "other bits do not count");

        wr(8'h08, ctrl_word(1, 2, 3, 3'b001, 2'b00), '0);
        read_chk(8'h08, exp_ctrl(), "R3", "status off after off code");
        run(3, 0);
        read_chk(8'h0C, 32'(m_cnt), "R7", "hold while off");

        wr(8'h08, ctrl_word(1, 2, 3, 3'b011, 2'b00), '0);
        read_chk(8'h0C, 32'(m_cnt), "R7", "enable keeps count");
        run(2, 0);
        read_chk(8'h0C, 32'd7, "R6", "count resumes");

        wr(8'h08, ctrl_word(1, 2, 3, 3'b101, 2'b10), only_selected());
        read_chk(8'h08, exp_ctrl(), "R3", "undefined enable code keeps state");
        read_chk(8'h0C, 32'd8, "R4", "undefined clear code and write-cycle pulse");

        wr(8'h0C, 32'h0, '0);
        wr(8'h10, ctrl_word(0, 0, 0, 3'b001, 2'b01), '0);
        read_chk(8'h0C, 32'd8, "R10", "data and other offsets ignored");
        read_chk(8'h08, exp_ctrl(), "R10", "ctrl unchanged by other offsets");
        read_chk(8'h10, 32'h0, "R10", "unmapped read is zero");

        wr(8'h08, ctrl_word(1, 2, 3, 3'b001, 2'b00), '0);
        wr(8'h08, ctrl_word(1, 2, 3, 3'b011, 2'b01), only_selected());
        read_chk(8'h0C, 32'd0, "R5", "clear with enable zeroes count");
        run(3, 0);
        read_chk(8'h0C, 32'd3, "R5", "counts up from zero");

        wr(8'h08, ctrl_word(0, 0, 0, 3'b000, 2'b00), '0);
        wr(8'h08, ctrl_word(0, 1, 2, 3'b000, 2'b00), (BUS)'(1));
        read_chk(8'h0C, 32'd4, "R6", "old selection counts in write cycle");

        wr(8'h08, ctrl_word(0, 0, 5, 3'b011, 2'b00), '0);
        run(10, 2);
        read_chk(8'h0C, 32'd4, "R8", "lane out of range");
        wr(8'h08, ctrl_word(8, 0, 0, 3'b011, 2'b00), '0);
        run(10, 2);
        read_chk(8'h0C, 32'd4, "R8", "group out of range");
        wr(8'h08, ctrl_word(0, 6, 0, 3'b011, 2'b00), '0);
        run(10, 2);
        read_chk(8'h0C, 32'd4, "R8", "event out of range");

        wr(8'h08, ctrl_word(7, 5, 3, 3'b011, 2'b01), '0);
        run((1 << CW) - 1, 0);
        read_chk(8'h0C, 32'((1 << CW) - 1), "R9", "count at top");
        run(1, 0);
        read_chk(8'h0C, 32'd0, "R9", "wrap to zero");
        run(2, 0);
        read_chk(8'h0C, 32'd2, "R9", "count after wrap");

        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom % 10);
            if (r < 6) begin
                run(1, 3);
            end else if (r < 8) begin
                logic [2:0] ec;
                case ($urandom % 6)
                    0: ec = 3'b000;
                    1: ec = 3'b001;
                    2, 3: ec = 3'b011;
                    4: ec = 3'b101;
                    default: ec = 3'($urandom);
                endcase
                wr(8'h08, ctrl_word(int'($urandom % 9), int'($urandom % 7), int'($urandom % 5),
                                    ec, 2'($urandom)), rand_pulses());
            end else if (r == 8) begin
                logic [7:0] a;
                a = 8'($urandom);
                if (a == 8'h08) a = 8'h0C;
                wr(AW'(a), $urandom, rand_pulses());
            end else begin
                read_chk(8'h0C, 32'(m_cnt), "R6", "random count");
                read_chk(8'h08, exp_ctrl(), "R2", "random ctrl");
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", total, fails);
        $finish;
    end

endmodule